// File: doc/BRIEF.md
# Time-Space Circuit Switch

The block is a two-stage circuit switch for sample streams. Several input trunks each carry a frame of time slots, one sample per slot and one slot per clock. Every trunk first enters its own time slot interchanger: a two-bank sample store that fills one bank with the current frame while it reads out the previous frame in an order set by a per-trunk slot map. The reordered samples then enter a small crossbar. The crossbar setting changes on every slot, so a sample that the interchanger has moved into the right slot crosses to the right output trunk. With two trunks of two slots, four endpoints get full connectivity from a 2x2 crossbar.

Slot maps and crossbar settings are computed elsewhere. They are written through a configuration port into shadow tables and made live by a commit request. The commit takes effect at the next frame boundary. A crossbar setting that steers two trunks to one output in the same slot is refused and flagged, and the live tables stay as they were.

Top module: `tsw_switch`

## Requirements
- R1: `in_slot` is 0 in the first cycle after reset and steps by one per clock, wrapping from NSLOT-1 to 0. The sample on lane t (`in_data[t*W +: W]`) is stored under the slot shown on `in_slot` at that clock edge.
- R2: In each frame, output slot s of trunk t's interchanger carries the sample that trunk t received in slot map[t][s] of the previous frame. Several entries of one map may name the same slot, which copies that sample into several output slots.
- R3: Output lane o (`out_data[o*W +: W]`) carries the interchanged sample of the trunk whose crossbar destination for that slot is o. After reset every map is the identity (map[t][s] = s) and every destination is straight (trunk t to output t).
- R4: The sample read for output slot s appears two clock edges after the edge at which `in_slot` equals s, and `out_slot` shows s alongside it.
- R5: `out_valid` stays 0 until one whole frame has been stored, rises after the edge numbered NSLOT+1 (counting the first edge after reset as 0), and then stays 1.
- R6: Configuration writes (`cfg_we` with `cfg_kind` 0 = slot map entry [cfg_trunk][cfg_slot] gets `cfg_val`, 1 = destination of trunk `cfg_trunk` in slot `cfg_slot` gets `cfg_val`) change only shadow tables and have no effect on the outputs until a commit.
- R7: A commit request (`cfg_commit` pulse) is applied at the first edge at which `in_slot` equals NSLOT-1. Every read from the next edge onward uses the new slot maps and destinations together, so no frame mixes old and new tables.
- R8: If, in any slot of the shadow destinations, two trunks name the same output, the commit is refused: `cfg_err` goes to 1 at that frame boundary and the live tables stay unchanged. An accepted commit clears `cfg_err`. `cfg_err` changes only at a frame boundary.
- R9: After reset `out_data` is 0, `out_valid` is 0, `cfg_err` is 0 and `in_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one time slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one shadow table entry |
| cfg_kind | input | 1 | 0 = slot map entry, 1 = crossbar destination |
| cfg_trunk | input | TW | Trunk index of the entry |
| cfg_slot | input | SW | Slot index of the entry |
| cfg_val | input | VW | Source slot (map) or output trunk (destination) |
| cfg_commit | input | 1 | Request that the shadow tables go live at the next frame boundary |
| cfg_err | output | 1 | The last commit was refused because of an output conflict |
| in_data | input | NTRK*W | One sample per input trunk for the current slot |
| in_slot | output | SW | Slot number that the current input cycle occupies |
| out_data | output | NTRK*W | One switched sample per output trunk |
| out_slot | output | SW | Output slot that the current `out_data` belongs to |
| out_valid | output | 1 | `out_data` holds switched samples |

## Verification
Each result has a fixed due time. `in_slot` moves at every edge. A sample read for output slot s shows on `out_data` two edges after the edge at which `in_slot` was s. A commit affects the reads that follow the boundary edge and moves `cfg_err` at that same edge. The bench counts edges from the release of reset, drives inputs and samples outputs on the falling edge, and uses its edge count to derive the read edge, frame and slot that each output belongs to. It then selects the tables that were live at that read edge, so switchover frames are checked exactly as well as steady ones.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  // Selects which shadow table a configuration write targets.
  typedef enum logic {
    K_TSI  = 1'b0,
    K_XBAR = 1'b1
  } tsw_kind_e;
endpackage

// File: rtl/tsw_cfg.sv
module tsw_cfg
  import tsw_pkg::*;
#(
  parameter int NTRK = 2,
  parameter int NSLOT = 2,
  parameter int SW = 1,
  parameter int TW = 1,
  parameter int VW = 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic                                   cfg_kind,
  input  logic [TW-1:0]                          cfg_trunk,
  input  logic [SW-1:0]                          cfg_slot,
  input  logic [VW-1:0]                          cfg_val,
  input  logic                                   cfg_commit,
  input  logic                                   boundary,
  output logic [NTRK-1:0][NSLOT-1:0][SW-1:0]     map_act,
  output logic [NSLOT-1:0][NTRK-1:0][TW-1:0]     dst_act,
  output logic                                   cfg_err
);
  logic [NTRK-1:0][NSLOT-1:0][SW-1:0] map_sh;
  logic [NSLOT-1:0][NTRK-1:0][TW-1:0] dst_sh;
  logic pending;
  logic sh_ok;
  logic idx_ok;
  logic apply;

  assign idx_ok = ({1'b0, cfg_trunk} < (TW+1)'(NTRK)) &&
                  ({1'b0, cfg_slot} < (SW+1)'(NSLOT));
  assign apply  = boundary && (pending || cfg_commit);

  // A slot is legal only if no two trunks share one output trunk.
  always_comb begin
    sh_ok = 1'b1;
    for (int s = 0; s < NSLOT; s++) begin
      for (int a = 0; a < NTRK; a++) begin
        for (int b = a + 1; b < NTRK; b++) begin
          if (dst_sh[s][a] == dst_sh[s][b]) sh_ok = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTRK; t++)
        for (int s = 0; s < NSLOT; s++) begin
          map_sh[t][s]  <= SW'(s);
          map_act[t][s] <= SW'(s);
          dst_sh[s][t]  <= TW'(t);
          dst_act[s][t] <= TW'(t);
        end
      pending <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_we && idx_ok) begin
        if (cfg_kind == K_XBAR) dst_sh[cfg_slot][cfg_trunk] <= cfg_val[TW-1:0];
        else                    map_sh[cfg_trunk][cfg_slot] <= cfg_val[SW-1:0];
      end
      if (apply) begin
        pending <= 1'b0;
        if (sh_ok) begin
          map_act <= map_sh;
          dst_act <= dst_sh;
          cfg_err <= 1'b0;
        end else begin
          cfg_err <= 1'b1;
        end
      end else if (cfg_commit) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsw_tsi.sv
module tsw_tsi #(
  parameter int W = 8,
  parameter int NSLOT = 2,
  parameter int SW = 1
) (
  input  logic          clk,
  input  logic          wr_bank,
  input  logic [SW-1:0] wr_addr,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] rd_addr,
  output logic [W-1:0]  rd_q
);
  localparam int DEPTH = 2 * NSLOT;
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wa;
  logic [AW-1:0] ra;

  // Bank 0 holds slots 0..NSLOT-1, bank 1 the next NSLOT words.
  assign wa = wr_bank ? AW'(NSLOT) + AW'(wr_addr) : AW'(wr_addr);
  assign ra = wr_bank ? AW'(rd_addr) : AW'(NSLOT) + AW'(rd_addr);

  always_ff @(posedge clk) begin
    mem[wa] <= din;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[ra];
  end
endmodule

// File: rtl/tsw_xbar.sv
module tsw_xbar #(
  parameter int W = 8,
  parameter int NTRK = 2,
  parameter int SW = 1,
  parameter int TW = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NTRK-1:0][W-1:0]      lane_in,
  input  logic [NTRK-1:0][TW-1:0]     dst,
  input  logic                        vld_in,
  input  logic [SW-1:0]               tag_in,
  output logic [NTRK-1:0][W-1:0]      lane_out,
  output logic                        vld_out,
  output logic [SW-1:0]               tag_out
);
  logic [NTRK-1:0][W-1:0] routed;

  always_comb begin
    for (int o = 0; o < NTRK; o++) begin
      routed[o] = '0;
      for (int t = 0; t < NTRK; t++) begin
        if (dst[t] == TW'(o)) routed[o] = routed[o] | lane_in[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_out <= '0;
      vld_out  <= 1'b0;
      tag_out  <= '0;
    end else begin
      lane_out <= routed;
      vld_out  <= vld_in;
      tag_out  <= tag_in;
    end
  end
endmodule

// File: rtl/tsw_switch.sv
module tsw_switch #(
  parameter int NTRK = 2,
  parameter int NSLOT = 2,
  parameter int W = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TW = (NTRK > 1) ? $clog2(NTRK) : 1,
  localparam int VW = (SW > TW) ? SW : TW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [TW-1:0]     cfg_trunk,
  input  logic [SW-1:0]     cfg_slot,
  input  logic [VW-1:0]     cfg_val,
  input  logic              cfg_commit,
  output logic              cfg_err,
  input  logic [NTRK*W-1:0] in_data,
  output logic [SW-1:0]     in_slot,
  output logic [NTRK*W-1:0] out_data,
  output logic [SW-1:0]     out_slot,
  output logic              out_valid
);
  logic [SW-1:0] slot;
  logic bank;
  logic full;
  logic boundary;

  logic [NTRK-1:0][NSLOT-1:0][SW-1:0] map_act;
  logic [NSLOT-1:0][NTRK-1:0][TW-1:0] dst_act;
  logic [NTRK-1:0][W-1:0] lanes;
  logic [NTRK-1:0][W-1:0] tsi_q;
  logic [NTRK-1:0][W-1:0] xo;
  logic [NTRK-1:0][TW-1:0] dst_q;
  logic [SW-1:0] tag_q;
  logic vld_q;

  assign boundary = (slot == SW'(NSLOT - 1));
  assign lanes    = in_data;
  assign in_slot  = slot;
  assign out_data = xo;

  // Slot and frame bank timing.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      bank <= 1'b0;
      full <= 1'b0;
    end else if (boundary) begin
      slot <= '0;
      bank <= ~bank;
      full <= 1'b1;
    end else begin
      slot <= slot + SW'(1);
    end
  end

  tsw_cfg #(
    .NTRK(NTRK), .NSLOT(NSLOT), .SW(SW), .TW(TW), .VW(VW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_trunk(cfg_trunk), .cfg_slot(cfg_slot), .cfg_val(cfg_val),
    .cfg_commit(cfg_commit), .boundary(boundary),
    .map_act(map_act), .dst_act(dst_act), .cfg_err(cfg_err)
  );

  for (genvar t = 0; t < NTRK; t++) begin : g_tsi
    tsw_tsi #(.W(W), .NSLOT(NSLOT), .SW(SW)) u_tsi (
      .clk(clk), .wr_bank(bank), .wr_addr(slot), .din(lanes[t]),
      .rd_addr(map_act[t][slot]), .rd_q(tsi_q[t])
    );
  end

  // Destinations are looked up in the same cycle as the map, so both
  // come from one table version.
  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q <= '0;
      tag_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dst_q <= dst_act[slot];
      tag_q <= slot;
      vld_q <= full;
    end
  end

  tsw_xbar #(.W(W), .NTRK(NTRK), .SW(SW), .TW(TW)) u_xbar (
    .clk(clk), .rst(rst), .lane_in(tsi_q), .dst(dst_q), .vld_in(vld_q),
    .tag_in(tag_q), .lane_out(xo), .vld_out(out_valid), .tag_out(out_slot)
  );
endmodule

// File: rtl/tsw_switch_chk.sv
module tsw_switch_chk #(
  parameter int NSLOT = 2,
  parameter int SW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] in_slot,
  input logic          cfg_err,
  input logic [SW-1:0] out_slot,
  input logic          out_valid
);
  a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
    (in_slot != SW'(NSLOT - 1)) |=> (in_slot == $past(in_slot) + SW'(1)));

  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_slot == SW'(NSLOT - 1)) |=> (in_slot == '0));

  a_r4_out_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot == $past(in_slot, 2)));

  a_r5_valid_holds: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  a_r8_err_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (in_slot != '0) |-> $stable(cfg_err));
endmodule

bind tsw_switch tsw_switch_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_slot(in_slot), .cfg_err(cfg_err),
  .out_slot(out_slot), .out_valid(out_valid)
);

// File: tb/tsw_switch_test.sv
module tsw_switch_test;
  localparam int NT = 2;
  localparam int NS = 2;
  localparam int W = 8;

  // Vector: bit (t*2+s) = source slot of trunk t map in slot s,
  // bit (4+s) = 1 if the crossbar exchanges trunks in slot s.
  localparam logic [5:0] VEC [6] = '{
    6'b00_10_10, 6'b00_10_01, 6'b11_10_10,
    6'b01_01_01, 6'b10_11_00, 6'b10_01_10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_commit = 1'b0;
  logic [0:0] cfg_trunk = '0, cfg_slot = '0, cfg_val = '0;
  logic cfg_err;
  logic [NT*W-1:0] in_data;
  logic [0:0] in_slot, out_slot;
  logic [NT*W-1:0] out_data;
  logic out_valid;

  always #2 clk = ~clk;

  tsw_switch #(.NTRK(NT), .NSLOT(NS), .W(W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_trunk(cfg_trunk), .cfg_slot(cfg_slot), .cfg_val(cfg_val),
    .cfg_commit(cfg_commit), .cfg_err(cfg_err), .in_data(in_data),
    .in_slot(in_slot), .out_data(out_data), .out_slot(out_slot),
    .out_valid(out_valid)
  );

  int n = 0, nchk = 0, nfail = 0, sw_edge = -1;
  bit live = 0, done = 0;
  string cur_req = "R3";
  int em_c[NT][NS], em_p[NT][NS], ed_c[NS][NT], ed_p[NS][NT];
  int sm[NT][NS], sd[NS][NT];

  function automatic logic [W-1:0] smp(int f, int t, int s);
    return W'((f * 16 + t * 4 + s) % 256);
  endfunction

  function automatic logic [NT*W-1:0] drive(int k);
    logic [NT*W-1:0] v;
    for (int t = 0; t < NT; t++) v[t*W +: W] = smp(k / NS, t, k % NS);
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n);
    end
  endtask

  // Output after edge n-1 was read at edge n-2; use the tables live then.
  task automatic chk_out();
    int r = n - 2;
    int fr = r / NS;
    int sp = r % NS;
    chk("R1 in_slot", int'(in_slot), n % NS);
    chk("R4 out_slot", int'(out_slot), sp);
    chk("R5 out_valid", int'(out_valid), 1);
    for (int o = 0; o < NT; o++) begin
      int src = 0;
      int mp;
      for (int t = 0; t < NT; t++)
        if (((r > sw_edge) ? ed_c[sp][t] : ed_p[sp][t]) == o) src = t;
      mp = (r > sw_edge) ? em_c[src][sp] : em_p[src][sp];
      chk({cur_req, " out lane"}, int'(out_data[o*W +: W]), int'(smp(fr - 1, src, mp)));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    n++;
    @(negedge clk);
    in_data = drive(n);
    if (live) chk_out();
  endtask

  task automatic wcfg(bit kind, int t, int s, int v);
    cfg_we = 1'b1; cfg_kind = kind;
    cfg_trunk = 1'(t); cfg_slot = 1'(s); cfg_val = 1'(v);
    tick();
    cfg_we = 1'b0;
    if (kind) sd[s][t] = v; else sm[t][s] = v;
  endtask

  task automatic commit(bit ok);
    int c = n;
    cfg_commit = 1'b1;
    tick();
    cfg_commit = 1'b0;
    if (ok) begin
      em_p = em_c; ed_p = ed_c;
      em_c = sm;   ed_c = sd;
      sw_edge = c + (NS - 1 - c % NS);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < NS; s++) begin
        em_c[t][s] = s; em_p[t][s] = s; sm[t][s] = s;
        ed_c[s][t] = t; ed_p[s][t] = t; sd[s][t] = t;
      end
    in_data = drive(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    in_data = drive(0);

    // R9 reset state
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 out_data", int'(out_data), 0);
    chk("R9 cfg_err", int'(cfg_err), 0);
    chk("R9 in_slot", int'(in_slot), 0);

    // R5 first valid output timing
    repeat (NS + 1) tick();
    chk("R5 out_valid low", int'(out_valid), 0);
    tick();
    chk("R5 out_valid high", int'(out_valid), 1);
    live = 1;
    repeat (2 * NS) tick();

    // R2 R3 R7: walk the configuration vectors
    foreach (VEC[i]) begin
      cur_req = "R2/R3";
      for (int t = 0; t < NT; t++)
        for (int s = 0; s < NS; s++) wcfg(1'b0, t, s, int'(VEC[i][t*2+s]));
      for (int s = 0; s < NS; s++)
        for (int t = 0; t < NT; t++) wcfg(1'b1, t, s, VEC[i][4+s] ? 1 - t : t);
      cur_req = "R7";
      commit(1'b1);
      repeat (3 * NS) tick();
      chk("R8 cfg_err after good commit", int'(cfg_err), 0);
    end

    // R6 shadow writes without commit leave outputs unchanged
    cur_req = "R6";
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NT; t++) wcfg(1'b1, t, s, 1 - t);
    for (int t = 0; t < NT; t++) wcfg(1'b0, t, 0, 1);
    repeat (3 * NS) tick();

    // R7 commit those writes
    cur_req = "R7";
    commit(1'b1);
    repeat (3 * NS) tick();

    // R8 conflicting destinations are refused, live tables kept
    cur_req = "R8";
    wcfg(1'b1, 0, 0, 0);
    commit(1'b0);
    repeat (2 * NS) tick();
    chk("R8 cfg_err set", int'(cfg_err), 1);
    wcfg(1'b1, 0, 0, 1);
    chk("R8 cfg_err held", int'(cfg_err), 1);
    commit(1'b1);
    repeat (2 * NS) tick();
    chk("R8 cfg_err cleared", int'(cfg_err), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule